// File: doc/BRIEF.md
# Parallel ADC Conversion Sequencer

This block is the host-side controller for a 12-bit sampling converter with a parallel output bus. It drives the converter's active-low start, select, read and power-down lines and watches its active-low busy flag. A pulse on the start request produces one full conversion: the controller selects the converter, drops the start strobe, releases it soon afterwards, waits for busy to rise again, reads the word and presents it with a one-cycle valid strobe.

Two power-down states are available. In the quick-wake state the select line is held low while power-down is asserted. In the slow-wake state it is held high. A start request issued while powered down first wakes the converter. The controller then waits the wake-up time of the state it left before it starts a conversion. Every delay is a count of system-clock cycles, computed from a clock-rate parameter and nanosecond or microsecond parameters. A converter that never completes a conversion is caught by a timeout.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Out of reset, `conv_n`, `sel_n`, `rd_n` and `pd_n` are all 1, and `dout_vld` and `tmo_err` are 0.
- R2: A falling edge on `conv_n` happens only while `sel_n` is low and was already low in the previous cycle, while `pd_n` is high, and while the synchronised busy line is high.
- R3: `conv_n` stays low for exactly START_CYC cycles (default 10), which is far below the 400 ns limit.
- R4: Once busy has risen, `sel_n` and `rd_n` are both low for exactly ACC_CYC cycles (default 4). Then `dout` takes the bus value, `dout_vld` is 1 for a single cycle, and `rd_n` returns high.
- R5: Two successive falling edges of `conv_n` are at least THRU_CYC cycles apart (default 80), including when `go_req` is held high.
- R6: A `go_req` that arrives while a conversion is running is remembered and produces one further conversion once the first has finished.
- R7: On `nap_req`, `sel_n` goes low one cycle before `pd_n` falls. On `slp_req`, `sel_n` stays high while `pd_n` is low.
- R8: A `go_req` in either power-down state raises `pd_n` with `sel_n` high. The next `conv_n` fall then comes no sooner than NAP_CYC cycles (quick wake, default 20) or SLP_CYC cycles (slow wake) after `pd_n` rises.
- R9: If busy has not completed a low-then-high cycle within TMO_CYC cycles (default 200) after `conv_n` rises, `tmo_err` is 1 for one cycle exactly TMO_CYC cycles after that rise, and all strobes return high.
- R10: In idle, a pending start wins over a pending slow-wake request, and that wins over a quick-wake request. A `nap_req` or `slp_req` received during power-down is dropped: the select level does not change, and the controller does not power down again after waking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| go_req | input | 1 | Request one conversion (held until served) |
| nap_req | input | 1 | Request quick-wake power-down |
| slp_req | input | 1 | Request slow-wake power-down |
| busy_n | input | 1 | Converter busy flag, low while converting |
| adc_bus | input | DW | Converter parallel data bus |
| conv_n | output | 1 | Conversion-start strobe, active low |
| sel_n | output | 1 | Chip select, active low; mode pick in power-down |
| rd_n | output | 1 | Read enable, active low |
| pd_n | output | 1 | Power-down, active low |
| dout | output | DW | Last captured conversion word |
| dout_vld | output | 1 | One-cycle strobe: `dout` is new |
| tmo_err | output | 1 | One-cycle strobe: busy did not complete in time |

## Verification
If the sequencer state goes wrong, the first thing to show it is the relation between the strobes, usually on the very cycle the strobe moves. A start edge with select high or power-down low, a start pulse that is too long, or a read without select are all seen there. A corrupted delay counter shows up later, as a measured start width, read width, start spacing, wake gap or timeout distance that differs from the parameter by one or more cycles. A lost or duplicated request shows up as a missing or extra valid strobe within one conversion period, or as a power-down that is never entered or that is entered again.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SETUP,
    S_START,
    S_CONV,
    S_READ,
    S_PDENT,
    S_PD,
    S_WAKE
  } seq_st_t;

  localparam int NREQ      = 3;
  localparam int REQ_GO    = 0;
  localparam int REQ_NAP   = 1;
  localparam int REQ_SLP   = 2;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int ns2cyc(input int mhz, input int ns);
    return (mhz * ns + 999) / 1000;
  endfunction

endpackage

// File: rtl/adc_seq_tmr.sv
module adc_seq_tmr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= {STAGES{RST_VAL}};
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/adc_seq_req.sv
module adc_seq_req #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)         pend[i] <= 1'b0;
      else if (set[i]) pend[i] <= 1'b1;
      else if (clr[i]) pend[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int DW          = 12,
  parameter int CLK_MHZ     = 100,
  parameter int T_START_NS  = 100,
  parameter int T_THRU_NS   = 800,
  parameter int T_NAP_NS    = 200,
  parameter int T_SLEEP_US  = 10000,
  parameter int T_ACC_NS    = 40,
  parameter int T_TMO_NS    = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go_req,
  input  logic          nap_req,
  input  logic          slp_req,
  input  logic          busy_n,
  input  logic [DW-1:0] adc_bus,
  output logic          conv_n,
  output logic          sel_n,
  output logic          rd_n,
  output logic          pd_n,
  output logic [DW-1:0] dout,
  output logic          dout_vld,
  output logic          tmo_err
);
  localparam int START_CYC = imax(ns2cyc(CLK_MHZ, T_START_NS), 1);
  localparam int THRU_CYC  = imax(ns2cyc(CLK_MHZ, T_THRU_NS), START_CYC + 1);
  localparam int NAP_CYC   = imax(ns2cyc(CLK_MHZ, T_NAP_NS), 1);
  localparam int SLP_CYC   = imax(CLK_MHZ * T_SLEEP_US, 1);
  localparam int ACC_CYC   = imax(ns2cyc(CLK_MHZ, T_ACC_NS), 1);
  localparam int TMO_CYC   = imax(ns2cyc(CLK_MHZ, T_TMO_NS), 1);
  localparam int MAX_CYC   = imax(imax(imax(START_CYC, THRU_CYC), imax(NAP_CYC, SLP_CYC)),
                                  imax(ACC_CYC, TMO_CYC));
  localparam int TW        = $clog2(MAX_CYC + 1) + 1;

  seq_st_t          st, st_nxt;
  logic             mode_slp, mode_nxt;
  logic             seen_low;
  logic             busy_s;
  logic             t_load, t_done, th_load, th_done;
  logic [TW-1:0]    t_val;
  logic [NREQ-1:0]  req_set, req_clr, pend;
  logic             cs_n_d;

  adc_seq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_bsync (
    .clk(clk), .rst(rst), .d(busy_n), .q(busy_s)
  );

  assign req_set = {slp_req, nap_req, go_req};

  adc_seq_req #(.N(NREQ)) u_req (
    .clk(clk), .rst(rst), .set(req_set), .clr(req_clr), .pend(pend)
  );

  adc_seq_tmr #(.W(TW)) u_step (
    .clk(clk), .rst(rst), .load(t_load), .val(t_val), .done(t_done)
  );

  adc_seq_tmr #(.W(TW)) u_thru (
    .clk(clk), .rst(rst), .load(th_load), .val(TW'(THRU_CYC - 1)), .done(th_done)
  );

  always_comb begin
    st_nxt   = st;
    mode_nxt = mode_slp;
    t_load   = 1'b0;
    t_val    = '0;
    th_load  = 1'b0;
    req_clr  = '0;
    unique case (st)
      S_IDLE: begin
        if (pend[REQ_GO] && th_done && busy_s) begin
          st_nxt           = S_SETUP;
          req_clr[REQ_GO]  = 1'b1;
        end else if (pend[REQ_SLP]) begin
          st_nxt           = S_PDENT;
          mode_nxt         = 1'b1;
          req_clr[REQ_SLP] = 1'b1;
          req_clr[REQ_NAP] = 1'b1;
        end else if (pend[REQ_NAP]) begin
          st_nxt           = S_PDENT;
          mode_nxt         = 1'b0;
          req_clr[REQ_NAP] = 1'b1;
        end
      end
      S_SETUP: begin
        st_nxt  = S_START;
        t_load  = 1'b1;
        t_val   = TW'(START_CYC - 1);
        th_load = 1'b1;
      end
      S_START: begin
        if (t_done) begin
          st_nxt = S_CONV;
          t_load = 1'b1;
          t_val  = TW'(TMO_CYC - 1);
        end
      end
      S_CONV: begin
        if (seen_low && busy_s) begin
          st_nxt = S_READ;
          t_load = 1'b1;
          t_val  = TW'(ACC_CYC - 1);
        end else if (t_done) begin
          st_nxt = S_IDLE;
        end
      end
      S_READ: begin
        if (t_done) st_nxt = S_IDLE;
      end
      S_PDENT: st_nxt = S_PD;
      S_PD: begin
        req_clr[REQ_NAP] = 1'b1;
        req_clr[REQ_SLP] = 1'b1;
        if (pend[REQ_GO]) begin
          st_nxt = S_WAKE;
          t_load = 1'b1;
          t_val  = mode_slp ? TW'(SLP_CYC - 1) : TW'(NAP_CYC - 1);
        end
      end
      S_WAKE: begin
        if (t_done) st_nxt = S_IDLE;
      end
      default: st_nxt = S_IDLE;
    endcase
  end

  always_comb begin
    unique case (st_nxt)
      S_SETUP, S_START, S_CONV, S_READ: cs_n_d = 1'b0;
      S_PDENT, S_PD:                    cs_n_d = mode_nxt;
      default:                          cs_n_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      mode_slp <= 1'b0;
      seen_low <= 1'b0;
      conv_n   <= 1'b1;
      sel_n    <= 1'b1;
      rd_n     <= 1'b1;
      pd_n     <= 1'b1;
      dout     <= '0;
      dout_vld <= 1'b0;
      tmo_err  <= 1'b0;
    end else begin
      st       <= st_nxt;
      mode_slp <= mode_nxt;
      conv_n   <= (st_nxt != S_START);
      sel_n    <= cs_n_d;
      rd_n     <= (st_nxt != S_READ);
      pd_n     <= (st_nxt != S_PD);
      if (st_nxt == S_SETUP)
        seen_low <= 1'b0;
      else if ((st == S_START || st == S_CONV) && !busy_s)
        seen_low <= 1'b1;
      dout_vld <= (st == S_READ) && t_done;
      if ((st == S_READ) && t_done) dout <= adc_bus;
      tmo_err  <= (st == S_CONV) && t_done && !(seen_low && busy_s);
    end
  end

  logic [TW-1:0] lo_cnt;
  logic [TW-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_cnt <= '0;
      gap    <= TW'(THRU_CYC);
    end else begin
      lo_cnt <= conv_n ? '0 : lo_cnt + 1'b1;
      if (!conv_n)                  gap <= '0;
      else if (gap < TW'(THRU_CYC)) gap <= gap + 1'b1;
    end
  end

  // R2
  start_sel_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(conv_n) |-> (!sel_n && $past(!sel_n) && pd_n && $past(busy_s)));

  // R3
  start_width_chk: assert property (@(posedge clk) disable iff (rst)
    !conv_n |-> (lo_cnt < TW'(START_CYC)));

  // R4
  read_sel_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !sel_n);

  // R4
  vld_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    dout_vld |=> !dout_vld);

  // R5
  start_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(conv_n) |-> (gap >= TW'(THRU_CYC - START_CYC)));

  // R7
  pd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !pd_n |-> (conv_n && rd_n));

  // R7
  pd_mode_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pd_n) |-> $stable(sel_n));

  // R9
  tmo_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tmo_err |-> (conv_n && rd_n && !dout_vld));
endmodule

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int START_CYC  = 10;
  localparam int THRU_CYC   = 80;
  localparam int NAP_CYC    = 20;
  localparam int SLP_CYC    = 500;
  localparam int ACC_CYC    = 4;
  localparam int TMO_CYC    = 200;
  localparam int CONV_CYC   = 60;
  localparam int WDOG       = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic go_req = 1'b0, nap_req = 1'b0, slp_req = 1'b0;
  logic busy_n = 1'b1;
  logic [11:0] adc_bus = '0;
  logic conv_n, sel_n, rd_n, pd_n, dout_vld, tmo_err;
  logic [11:0] dout;

  int n_tot = 0, n_bad = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_seq_ctrl #(.T_SLEEP_US(5)) u_dut (
    .clk(clk), .rst(rst), .go_req(go_req), .nap_req(nap_req), .slp_req(slp_req),
    .busy_n(busy_n), .adc_bus(adc_bus), .conv_n(conv_n), .sel_n(sel_n),
    .rd_n(rd_n), .pd_n(pd_n), .dout(dout), .dout_vld(dout_vld), .tmo_err(tmo_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tot++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [11:0] pat(input int i);
    return 12'h3C5 + 12'(i * 273);
  endfunction

  // converter model and monitor, both on the falling edge
  bit model_on = 1'b1;
  bit conv_act = 1'b0;
  int conv_left = 0, conv_idx = 0;
  logic [11:0] exp_word = '0;
  logic p_conv = 1'b1, p_sel = 1'b1, p_rd = 1'b1, p_pd = 1'b1;
  int last_fall = -1, fall_cnt = 0, lo_w = 0, last_w = 0;
  int rd_run = 0, rd_w = 0, rd_cs_bad = 0;
  int pd_rise = -1, wake_gap = -1, rise_cyc = 0, err_cyc = -1, err_len = 0, err_run = 0;
  int n_vld = 0;
  logic [11:0] last_dout = '0;
  bit exp_slp = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (conv_act) begin
        conv_left--;
        if (conv_left == 0) begin
          conv_act = 1'b0;
          busy_n   = 1'b1;
          adc_bus  = pat(conv_idx);
          exp_word = pat(conv_idx);
        end
      end
      if (p_conv && !conv_n) begin
        // R2 start edge conditions
        chk(!sel_n && !p_sel && pd_n, "R2 start needs select low and power up", {sel_n, p_sel, pd_n}, 0);
        if (last_fall >= 0)
          chk(cyc - last_fall >= THRU_CYC, "R5 start spacing", cyc - last_fall, THRU_CYC);
        if (pd_rise >= 0) begin
          wake_gap = cyc - pd_rise;
          pd_rise  = -1;
        end
        last_fall = cyc;
        fall_cnt++;
        if (model_on && !conv_act) begin
          conv_act  = 1'b1;
          conv_left = CONV_CYC;
          conv_idx++;
          busy_n    = 1'b0;
        end
      end
      lo_w = conv_n ? 0 : lo_w + 1;
      if (!p_conv && conv_n) begin
        last_w   = lo_w_prev;
        rise_cyc = cyc;
      end
      if (!rd_n) begin
        rd_run++;
        if (sel_n) rd_cs_bad++;
      end else if (!p_rd) begin
        rd_w   = rd_run;
        rd_run = 0;
      end
      if (!p_pd && pd_n) pd_rise = cyc;
      if (tmo_err) begin
        if (err_run == 0) err_cyc = cyc;
        err_run++;
        err_len = err_run;
      end else err_run = 0;
      if (dout_vld) begin
        n_vld++;
        last_dout = dout;
      end
      lo_w_prev = lo_w;
      p_conv = conv_n; p_sel = sel_n; p_rd = rd_n; p_pd = pd_n;
      if (cyc > WDOG) begin
        n_bad++;
        n_tot++;
        $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WDOG);
        $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
      end
    end
  end
  int lo_w_prev = 0;

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic pulse(input int which);
    @(posedge clk); #1;
    if (which == 0) go_req = 1'b1;
    if (which == 1) nap_req = 1'b1;
    if (which == 2) slp_req = 1'b1;
    @(posedge clk); #1;
    go_req = 1'b0; nap_req = 1'b0; slp_req = 1'b0;
  endtask

  task automatic wait_vld(input int target, input string req);
    int lim = 0;
    while (n_vld < target && lim < 2000) begin
      @(negedge clk); lim++;
    end
    chk(n_vld >= target, req, n_vld, target);
    ticks(2);
  endtask

  task automatic t_reset();
    chk(conv_n && sel_n && rd_n && pd_n, "R1 strobes high after reset", {conv_n, sel_n, rd_n, pd_n}, 4'hF);
    chk(!dout_vld && !tmo_err, "R1 flags low after reset", {dout_vld, tmo_err}, 0);
  endtask

  task automatic t_single();
    int base = n_vld;
    pulse(0);
    wait_vld(base + 1, "R4 single conversion delivers");
    chk(last_dout == exp_word, "R4 captured word", last_dout, exp_word);
    chk(last_w == START_CYC, "R3 start strobe width", last_w, START_CYC);
    chk(rd_w == ACC_CYC, "R4 read strobe width", rd_w, ACC_CYC);
    chk(rd_cs_bad == 0, "R4 select low during read", rd_cs_bad, 0);
    chk(rd_n && sel_n && conv_n, "R4 strobes back high", {rd_n, sel_n, conv_n}, 7);
  endtask

  task automatic t_burst();
    int base = n_vld;
    @(posedge clk); #1; go_req = 1'b1;
    ticks(300);
    go_req = 1'b0;
    wait_vld(base + 3, "R5 held request repeats");
    ticks(THRU_CYC + 100);
    chk(last_dout == exp_word, "R5 burst last word", last_dout, exp_word);
  endtask

  task automatic t_held();
    int base = n_vld;
    int f0 = fall_cnt;
    pulse(0);
    while (busy_n) @(negedge clk);
    ticks(5);
    pulse(0);
    wait_vld(base + 2, "R6 request during conversion kept");
    ticks(THRU_CYC + 40);
    chk(fall_cnt - f0 == 2, "R6 exactly two conversions", fall_cnt - f0, 2);
    chk(n_vld - base == 2, "R6 two words delivered", n_vld - base, 2);
  endtask

  task automatic t_nap();
    int base = n_vld;
    pulse(1);
    ticks(5);
    chk(!pd_n && !sel_n, "R7 quick-wake power-down with select low", {pd_n, sel_n}, 0);
    pulse(0);
    wait_vld(base + 1, "R8 conversion after quick wake");
    chk(wake_gap >= NAP_CYC, "R8 quick-wake delay", wake_gap, NAP_CYC);
    chk(last_dout == exp_word, "R8 word after quick wake", last_dout, exp_word);
  endtask

  task automatic t_sleep();
    int base = n_vld;
    pulse(2);
    ticks(5);
    chk(!pd_n && sel_n, "R7 slow-wake power-down with select high", {pd_n, sel_n}, 1);
    pulse(1);
    ticks(10);
    chk(!pd_n && sel_n, "R10 nap request ignored in slow-wake state", {pd_n, sel_n}, 1);
    pulse(0);
    wait_vld(base + 1, "R8 conversion after slow wake");
    chk(wake_gap >= SLP_CYC, "R8 slow-wake delay", wake_gap, SLP_CYC);
    ticks(100);
    chk(pd_n && sel_n, "R10 dropped request does not power down again", {pd_n, sel_n}, 3);
  endtask

  task automatic t_prio();
    int base = n_vld;
    @(posedge clk); #1; go_req = 1'b1; slp_req = 1'b1;
    @(posedge clk); #1; go_req = 1'b0; slp_req = 1'b0;
    wait_vld(base + 1, "R10 start served before power-down");
    ticks(5);
    chk(!pd_n && sel_n, "R10 slow-wake entered after conversion", {pd_n, sel_n}, 1);
    pulse(0);
    wait_vld(base + 2, "R10 wake after priority case");
  endtask

  task automatic t_timeout();
    int base = n_vld;
    ticks(THRU_CYC);
    model_on = 1'b0;
    err_cyc = -1;
    pulse(0);
    ticks(START_CYC + TMO_CYC + 30);
    chk(err_cyc >= 0, "R9 timeout flagged", err_cyc, 1);
    chk(err_cyc - rise_cyc == TMO_CYC, "R9 timeout distance", err_cyc - rise_cyc, TMO_CYC);
    chk(err_len == 1, "R9 timeout one cycle", err_len, 1);
    chk(conv_n && sel_n && rd_n && pd_n, "R9 strobes high after timeout", {conv_n, sel_n, rd_n, pd_n}, 4'hF);
    chk(n_vld == base, "R9 no word on timeout", n_vld, base);
    model_on = 1'b1;
    pulse(0);
    wait_vld(base + 1, "R9 recovery after timeout");
  endtask

  initial begin
    ticks(4);
    rst = 1'b0;
    ticks(1);
    t_reset();
    t_single();
    t_burst();
    t_held();
    t_nap();
    t_sleep();
    t_prio();
    t_timeout();
    ticks(10);
    $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end
endmodule